// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the master clock waveform for an I2C bus. A prescaler divides the system clock by a power of two to make an internal tick. The low half and the high half of each SCL period are each counted in ticks. Each half lasts its programmed 5-bit count plus a fixed overhead. The overhead is 4 ticks when the prescaler is bypassed and 3 ticks at any other setting. The block drives SCL only by pulling it low (open drain). It reads the bus level back through a two-stage synchronizer and a glitch filter. The high half does not go past its hold point until that filtered level is high, so a slave that keeps SCL low stretches the period.

The byte engine next to the block gets two single-cycle strobes in every SCL period. The setup strobe marks the start of the low phase, when SDA may change. The sample strobe marks the point in the high phase where SCL has been confirmed high, when SDA may be read. The prescaler and both counts are captured at the start of each SCL period. A change to them takes effect from the next period.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted, scl_drive_low, setup_stb and sample_stb are 0. One clock after en is sampled low, scl_drive_low is 0, and no strobe fires while en stays low.
- R2: The internal tick comes once every 2^pre_sel system clocks (pre_sel = 0 gives a tick on every clock). Every duration in ticks below is scaled by this factor in system clocks.
- R3: The low phase (scl_drive_low = 1) lasts low_cnt + 4 ticks when pre_sel = 0, and low_cnt + 3 ticks otherwise.
- R4: If no device holds SCL low, the high phase (scl_drive_low = 0, from its fall to the next rise) lasts high_cnt + 4 ticks when pre_sel = 0, and high_cnt + 3 ticks otherwise.
- R5: A low_cnt or high_cnt of 0 is counted as 1.
- R6: When an external device holds SCL low after release, the high phase and the sample strobe are each delayed by the number of ticks by which the first high sample of scl_in is delayed.
- R7: A high pulse on scl_in that lasts a single tick is filtered out and does not end a stretch.
- R8: With no stretch, sample_stb pulses for one clock exactly 4 ticks after scl_drive_low falls. That is 2 ticks of synchronizer, 1 tick of filter and 1 tick to register the result.
- R9: setup_stb pulses for one clock in the same cycle that scl_drive_low rises. Exactly one sample_stb pulse comes between a fall of scl_drive_low and the next rise.
- R10: pre_sel, low_cnt and high_cnt are captured when a low phase begins. A change during a period does not affect that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run the generator; low releases SCL and idles |
| pre_sel | input | PRE_W (3) | Prescaler exponent, tick = clk / 2^pre_sel |
| low_cnt | input | CNT_W (5) | Low half-period count |
| high_cnt | input | CNT_W (5) | High half-period count |
| scl_in | input | 1 | Raw SCL bus level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| setup_stb | output | 1 | One-clock strobe at the start of the low phase |
| sample_stb | output | 1 | One-clock strobe when SCL is confirmed high |

## Verification
Every result is timed in ticks from the edge at which scl_drive_low changed. The fall is due (count + overhead) × 2^pre_sel clocks after the rise. The sample strobe is due 4 ticks plus any stretch after the fall, and the next rise is due (count + overhead) ticks plus the stretch after the fall. The setup strobe shows in the same cycle as the rise. The bench counts negative edges from each observed transition and compares each of these distances to the value its own functions compute. Stretches and glitches are driven at exact negative edges counted from the fall, so the delay they add is a whole number of ticks that is known in advance.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int CNT_W = 5,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             setup_stb,
  output logic             sample_stb
);
  localparam int DIV_W    = (1 << PRE_W) - 1;
  localparam int LEN_W    = CNT_W + 1;
  localparam int OVH_FULL = 4;
  localparam int OVH_DIV  = 3;
  localparam int HOLD_AT  = 3;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_LOW = 2'd1, PH_HIGH = 2'd2;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic [DIV_W-1:0] div_q, div_mask;
  logic [LEN_W-1:0] cnt, ovh, low_len, high_len;
  logic [1:0]       phase;
  logic             s1, s2, filt, drv;
  logic             tick, in_low, in_high, at_hold, advance_hi;

  assign div_mask = DIV_W'((1 << pre_q) - 1);
  assign tick     = en && (div_q >= div_mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            div_q <= '0;
    else if (!en || tick)  div_q <= '0;
    else                   div_q <= div_q + DIV_W'(1);

  assign ovh      = (pre_q == '0) ? LEN_W'(OVH_FULL) : LEN_W'(OVH_DIV);
  assign low_len  = ((lo_q == '0) ? LEN_W'(1) : LEN_W'(lo_q)) + ovh;
  assign high_len = ((hi_q == '0) ? LEN_W'(1) : LEN_W'(hi_q)) + ovh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; filt <= 1'b0;
    end else if (tick) begin
      s1 <= scl_in;
      s2 <= s1;
      if (s1 == s2) filt <= s2;
    end

  assign in_low     = (phase == PH_LOW);
  assign in_high    = (phase == PH_HIGH);
  assign at_hold    = (cnt >= LEN_W'(HOLD_AT));
  assign advance_hi = !at_hold || filt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= PH_IDLE; cnt <= '0; drv <= 1'b0;
      setup_stb <= 1'b0; sample_stb <= 1'b0;
      pre_q <= '0; lo_q <= '0; hi_q <= '0;
    end else begin
      setup_stb  <= 1'b0;
      sample_stb <= 1'b0;
      if (!en) begin
        phase <= PH_IDLE; cnt <= '0; drv <= 1'b0;
        pre_q <= pre_sel; lo_q <= low_cnt; hi_q <= high_cnt;
      end else if (tick) begin
        if (in_low) begin
          if (cnt == low_len - LEN_W'(1)) begin
            phase <= PH_HIGH; cnt <= '0; drv <= 1'b0;
          end else cnt <= cnt + LEN_W'(1);
        end else if (in_high) begin
          if (advance_hi) begin
            if (cnt == LEN_W'(HOLD_AT)) sample_stb <= 1'b1;
            if (cnt == high_len - LEN_W'(1)) begin
              phase <= PH_LOW; cnt <= '0; drv <= 1'b1; setup_stb <= 1'b1;
              pre_q <= pre_sel; lo_q <= low_cnt; hi_q <= high_cnt;
            end else cnt <= cnt + LEN_W'(1);
          end
        end else begin
          phase <= PH_LOW; cnt <= '0; drv <= 1'b1; setup_stb <= 1'b1;
          pre_q <= pre_sel; lo_q <= low_cnt; hi_q <= high_cnt;
        end
      end else if (phase == PH_IDLE) begin
        pre_q <= pre_sel; lo_q <= low_cnt; hi_q <= high_cnt;
      end
    end

  assign scl_drive_low = drv;
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_drive_low,
  input logic setup_stb,
  input logic sample_stb,
  input logic in_high,
  input logic at_hold,
  input logic filt
);
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_drive_low); // R1
  AST_SETUP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb |-> (scl_drive_low && !$past(scl_drive_low))); // R9
  AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb |=> !setup_stb); // R9
  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb); // R9
  AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !$past(scl_drive_low)); // R8
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_high && at_hold && !filt) |=> !scl_drive_low); // R6
  AST_LOW_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $rose(scl_drive_low)) |=> scl_drive_low); // R3
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_drive_low(scl_drive_low),
  .setup_stb(setup_stb), .sample_stb(sample_stb),
  .in_high(in_high), .at_hold(at_hold), .filt(filt)
);

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, stretch_low = 1'b0;
  logic [2:0] pre_sel = 3'd0;
  logic [4:0] low_cnt = 5'd2, high_cnt = 5'd2;
  logic scl_in, drv, setup_stb, sample_stb, prev_d;
  int   tests = 0, fails = 0, cyc = 0;
  int   cur_p = 0, cur_lo = 2, cur_hi = 2;
  bit   done = 0;

  always #5 clk = ~clk;
  assign scl_in = !(drv || stretch_low);

  scl_rate_gen u_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .pre_sel(pre_sel), .low_cnt(low_cnt),
    .high_cnt(high_cnt), .scl_in(scl_in), .scl_drive_low(drv),
    .setup_stb(setup_stb), .sample_stb(sample_stb));

  function automatic int half_len(int p, int c);
    return ((c == 0) ? 1 : c) + ((p == 0) ? 4 : 3);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    prev_d = drv;
    @(negedge clk);
    cyc++;
  endtask

  task automatic wait_rise();
    do step(); while (!(drv && !prev_d));
  endtask

  task automatic wait_fall();
    do step(); while (!(!drv && prev_d));
  endtask

  task automatic run_cycle(int p, int lo, int hi, int s_len, bit glitch, string req);
    int r0, r, f, s, r2, nsmp, old_low;
    old_low = half_len(cur_p, cur_lo) << cur_p;
    wait_rise(); r0 = cyc;
    pre_sel = 3'(p); low_cnt = 5'(lo); high_cnt = 5'(hi);
    wait_fall();
    chk((cyc - r0) == old_low, "R10 low of running period", cyc - r0, old_low);
    wait_rise(); r = cyc;
    cur_p = p; cur_lo = lo; cur_hi = hi;
    chk(setup_stb == 1'b1, "R9 setup_stb at rise", int'(setup_stb), 1);
    stretch_low = (s_len > 0);
    wait_fall(); f = cyc;
    chk((f - r) == (half_len(p, lo) << p), {req, " R3 low length"}, f - r, half_len(p, lo) << p);
    nsmp = 0; s = -1;
    do begin
      step();
      if (s_len > 0) begin
        if (glitch && cyc == f + 1) stretch_low = 1'b0;
        if (glitch && cyc == f + 2) stretch_low = 1'b1;
        if (cyc == f + s_len) stretch_low = 1'b0;
      end
      if (sample_stb) begin nsmp++; if (s < 0) s = cyc; end
    end while (!(drv && !prev_d));
    r2 = cyc;
    chk(nsmp == 1, "R9 one sample_stb per period", nsmp, 1);
    chk((s - f) == ((4 << p) + s_len), {req, " R8 sample_stb timing"}, s - f, (4 << p) + s_len);
    chk((r2 - f) == ((half_len(p, hi) << p) + s_len), {req, " R4 high length"},
        r2 - f, (half_len(p, hi) << p) + s_len);
    chk(setup_stb == 1'b1, "R9 setup_stb at next rise", int'(setup_stb), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int anyact;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!drv && !setup_stb && !sample_stb, "R1 reset state", int'({drv, setup_stb, sample_stb}), 0);
    rst_n = 1'b1;
    anyact = 0;
    repeat (20) begin @(negedge clk); if (drv || setup_stb || sample_stb) anyact++; end
    chk(anyact == 0, "R1 idle while disabled", anyact, 0);
    en = 1'b1;
    run_cycle(0, 0, 0, 0, 0, "R5 zero counts");
    run_cycle(0, 31, 31, 0, 0, "R3 max counts");
    run_cycle(1, 0, 5, 0, 0, "R2 prescale 2");
    run_cycle(7, 31, 31, 0, 0, "R2 prescale 128");
    run_cycle(0, 3, 2, 2, 0, "R6 stretch");
    run_cycle(0, 1, 1, 6, 1, "R7 glitch in stretch");
    for (int i = 0; i < 30; i++) begin
      int p, sl; bit g;
      p  = int'($urandom_range(3, 0));
      sl = (p == 0) ? int'($urandom_range(6, 0)) : 0;
      g  = (sl >= 4) && $urandom_range(1, 0) == 1;
      run_cycle(p, int'($urandom_range(31, 0)), int'($urandom_range(31, 0)), sl, g,
                g ? "R7 random" : (sl > 0 ? "R6 random" : "R2 random"));
    end
    wait_rise();
    en = 1'b0;
    @(negedge clk);
    chk(drv == 1'b0, "R1 release on disable", int'(drv), 0);
    anyact = 0;
    repeat (10) begin @(negedge clk); if (drv || setup_stb || sample_stb) anyact++; end
    chk(anyact == 0, "R1 quiet after disable", anyact, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule